// File: doc/BRIEF.md
# Tape Record Framer and Deframer

This block sits between a byte-wide payload stream and a byte-wide storage stream that holds tape records. The write side (framer) accepts a start request with a byte count and an error flag. It then emits a four-byte length word, the payload bytes, one zero filler byte when the count is odd, and a second copy of the length word. A count of zero writes a file mark, which is a single all-zero length word with nothing after it.

The read side (deframer) consumes storage bytes. It can walk the tape forward or in reverse: in reverse the stream arrives byte-reversed, so the trailing length word comes first and the payload comes last byte first. It strips the framing and forwards the payload with a last-byte marker. For each record or mark it raises a one-cycle event carrying a code and the record length. The events report good records, records flagged bad by the sign bit of the length, file marks, end of tape (a second mark in a row), and invalid lengths. Both streams use valid/ready handshakes, and the payload passes through the block with no added latency.

Top module: `tape_rec_codec`

## Requirements
- R1: After a write start with a nonzero count N (N not above MAX_LEN), the storage output carries the 32-bit word {flag, N[30:0]} least-significant byte first. The N payload bytes follow unchanged and in order, and then the identical four-byte word again. wr_busy is high from the cycle after the start until the last byte is taken.
- R2: When N is odd, exactly one byte of value 0x00 is emitted between the last payload byte and the trailing word. When N is even, no filler byte is emitted.
- R3: A write start with N = 0 emits exactly four 0x00 bytes and nothing else, whatever the flag input holds.
- R4: A write start with N greater than MAX_LEN emits nothing, leaves wr_busy low, and pulses wr_reject high for one cycle, visible in the cycle after the start.
- R5: Forward read (rd_reverse = 0): the payload of a record whose length word has bit 31 clear is forwarded in storage order. pay_out_last is high only with the final byte, and the filler byte is dropped. One cycle after the last trailer byte is accepted, evt_valid pulses with evt_code = 1 and evt_len = N.
- R6: Reverse read (rd_reverse = 1, sampled with the first byte of a length word): the length word arrives most-significant byte first and the filler (odd N) precedes the payload. The payload is forwarded last byte first, and the same event as in R5 is reported.
- R7: An all-zero length word produces evt_code = 3 (file mark) with evt_len = 0, one cycle after its fourth byte. When the record event just before it was also a mark, the code is 4 (end of tape) instead. Any other event breaks the run.
- R8: A length word with bit 31 set is a flagged record. Its data and filler bytes are consumed but not forwarded, and the event carries evt_code = 2 and evt_len = the low 31 bits.
- R9: If the trailing length word differs from the leading one, the event carries evt_code = 5 (invalid length). The next byte is parsed as the start of a new length word.
- R10: A leading length word whose low 31 bits exceed MAX_LEN yields evt_code = 5 one cycle after its fourth byte. No byte of it is forwarded, and the next byte starts a new length word.
- R11: Under backpressure on either output stream, no byte is lost or repeated, and a held framing byte stays stable until it is taken.
- R12: After reset, wr_busy, sto_out_valid, pay_out_valid and evt_valid are low, and the deframer is ready for a length word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Request to frame one record (taken when not busy) |
| wr_len | input | 31 | Byte count of the record to write |
| wr_flag | input | 1 | Marks the written record as bad (bit 31 of the length word) |
| wr_busy | output | 1 | Framer is emitting a record |
| wr_reject | output | 1 | One-cycle pulse: start refused, count too large |
| pay_in_valid | input | 1 | Write payload byte valid |
| pay_in_ready | output | 1 | Write payload byte taken |
| pay_in_data | input | 8 | Write payload byte |
| sto_out_valid | output | 1 | Storage byte valid (write side) |
| sto_out_ready | input | 1 | Storage sink takes the byte |
| sto_out_data | output | 8 | Storage byte (write side) |
| rd_reverse | input | 1 | Read direction, 1 = reverse |
| sto_in_valid | input | 1 | Storage byte valid (read side) |
| sto_in_ready | output | 1 | Deframer takes the storage byte |
| sto_in_data | input | 8 | Storage byte (read side) |
| pay_out_valid | output | 1 | Read payload byte valid |
| pay_out_ready | input | 1 | Read payload sink takes the byte |
| pay_out_data | output | 8 | Read payload byte |
| pay_out_last | output | 1 | Final payload byte of the record |
| evt_valid | output | 1 | One-cycle record event |
| evt_code | output | 3 | 1 good, 2 flagged, 3 mark, 4 end of tape, 5 invalid length |
| evt_len | output | 17 | Length carried with the event |

## Verification
Storage bytes and payload bytes pass through combinationally. A byte moves on the rising edge where valid and ready are both high, so the bench drives inputs just after a falling edge and samples outputs before the next rising edge. The first length byte appears in the cycle after the edge that takes wr_start, and the same edge registers wr_reject, so it is checked in that cycle. Record events are registered and are due one cycle after the edge that accepts the last trailer byte, or the fourth byte of a mark or an oversized word. The bench keeps stepping for several idle cycles after the last byte so that every event is collected and counted exactly once.

// File: rtl/tape_rec_pkg.sv
package tape_rec_pkg;

    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        EVT_NONE    = 3'd0,
        EVT_GOOD    = 3'd1,
        EVT_FLAGGED = 3'd2,
        EVT_MARK    = 3'd3,
        EVT_END     = 3'd4,
        EVT_BADLEN  = 3'd5
    } evt_e;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_HEAD     = 3'd1,
        PH_LEAD_PAD = 3'd2,
        PH_BODY     = 3'd3,
        PH_TAIL_PAD = 3'd4,
        PH_TAIL     = 3'd5
    } phase_e;

    // accumulate one byte of a length word; forward streams deliver the
    // low byte first, reverse streams deliver the high byte first
    function automatic logic [31:0] shift_in(input logic [31:0] w,
                                             input logic [7:0]  b,
                                             input logic        rev);
        return rev ? {w[23:0], b} : {b, w[31:8]};
    endfunction

    function automatic logic [7:0] pick_byte(input logic [31:0] w,
                                             input logic [1:0]  i);
        return 8'(w >> {i, 3'b000});
    endfunction

endpackage

// File: rtl/tape_rec_framer.sv
module tape_rec_framer
    import tape_rec_pkg::*;
#(
    parameter int MAX_LEN = 65536,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [30:0] len_i,
    input  logic        flag_i,
    output logic        busy_o,
    output logic        reject_o,
    input  logic        pay_valid_i,
    output logic        pay_ready_o,
    input  logic [7:0]  pay_data_i,
    output logic        sto_valid_o,
    input  logic        sto_ready_i,
    output logic [7:0]  sto_data_o
);

    typedef struct packed {
        phase_e             phase;
        logic [31:0]        word;
        logic [CNT_W-1:0]   len;
        logic [CNT_W-1:0]   cnt;
        logic [1:0]         idx;
        logic               reject;
    } fr_st_t;

    fr_st_t q, d;

    always_comb begin
        d           = q;
        d.reject    = 1'b0;
        sto_valid_o = 1'b0;
        sto_data_o  = 8'h00;
        pay_ready_o = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    if ({1'b0, len_i} > 32'(MAX_LEN)) begin
                        d.reject = 1'b1;
                    end else begin
                        d.phase = PH_HEAD;
                        d.word  = (len_i == '0) ? 32'h0 : {flag_i, len_i};
                        d.len   = len_i[CNT_W-1:0];
                        d.cnt   = '0;
                        d.idx   = '0;
                    end
                end
            end
            PH_HEAD: begin
                sto_valid_o = 1'b1;
                sto_data_o  = pick_byte(q.word, q.idx);
                if (sto_ready_i) begin
                    d.idx = q.idx + 2'd1;
                    if (q.idx == 2'(WORD_BYTES - 1)) begin
                        d.phase = (q.len == '0) ? PH_IDLE : PH_BODY;
                    end
                end
            end
            PH_BODY: begin
                sto_valid_o = pay_valid_i;
                sto_data_o  = pay_data_i;
                pay_ready_o = sto_ready_i;
                if (pay_valid_i && sto_ready_i) begin
                    d.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == q.len - CNT_W'(1)) begin
                        d.phase = q.len[0] ? PH_TAIL_PAD : PH_TAIL;
                        d.idx   = '0;
                    end
                end
            end
            PH_TAIL_PAD: begin
                sto_valid_o = 1'b1;
                sto_data_o  = 8'h00;
                if (sto_ready_i) d.phase = PH_TAIL;
            end
            PH_TAIL: begin
                sto_valid_o = 1'b1;
                sto_data_o  = pick_byte(q.word, q.idx);
                if (sto_ready_i) begin
                    d.idx = q.idx + 2'd1;
                    if (q.idx == 2'(WORD_BYTES - 1)) d.phase = PH_IDLE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o   = (q.phase != PH_IDLE);
    assign reject_o = q.reject;

    // a framing byte held back by the sink must not change
    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sto_valid_o && !sto_ready_i && q.phase != PH_BODY)
        |=> (sto_valid_o && $stable(sto_data_o)));

    // a refused start never begins a record
    assert_reject_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.reject |-> (q.phase == PH_IDLE));

    assert_body_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_BODY) |-> (q.cnt < q.len));

endmodule

// File: rtl/tape_rec_deframer.sv
module tape_rec_deframer
    import tape_rec_pkg::*;
#(
    parameter int MAX_LEN = 65536,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rev_i,
    input  logic             sto_valid_i,
    output logic             sto_ready_o,
    input  logic [7:0]       sto_data_i,
    output logic             pay_valid_o,
    input  logic             pay_ready_i,
    output logic [7:0]       pay_data_o,
    output logic             pay_last_o,
    output logic             evt_valid_o,
    output logic [2:0]       evt_code_o,
    output logic [CNT_W-1:0] evt_len_o
);

    typedef struct packed {
        phase_e           phase;
        logic             rev;
        logic [31:0]      head;
        logic [31:0]      tail;
        logic [1:0]       idx;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        logic             flagged;
        logic             prev_mark;
        logic             evt_valid;
        evt_e             evt_code;
        logic [CNT_W-1:0] evt_len;
    } df_st_t;

    df_st_t q, d;

    logic        rev_now;
    logic [31:0] hw;
    logic [31:0] tw;
    logic        body_end;

    always_comb begin
        d           = q;
        d.evt_valid = 1'b0;
        sto_ready_o = 1'b0;
        pay_valid_o = 1'b0;
        pay_data_o  = sto_data_i;
        pay_last_o  = 1'b0;
        rev_now     = (q.idx == 2'd0) ? rev_i : q.rev;
        hw          = shift_in(q.head, sto_data_i, rev_now);
        tw          = shift_in(q.tail, sto_data_i, q.rev);
        body_end    = (q.cnt == q.len - CNT_W'(1));
        case (q.phase)
            PH_HEAD: begin
                sto_ready_o = 1'b1;
                if (sto_valid_i) begin
                    d.rev  = rev_now;
                    d.head = hw;
                    d.idx  = q.idx + 2'd1;
                    if (q.idx == 2'(WORD_BYTES - 1)) begin
                        d.idx = '0;
                        d.cnt = '0;
                        if (hw == 32'h0) begin
                            d.evt_valid = 1'b1;
                            d.evt_code  = q.prev_mark ? EVT_END : EVT_MARK;
                            d.evt_len   = '0;
                            d.prev_mark = 1'b1;
                        end else if (hw[30:0] > 31'(MAX_LEN)) begin
                            d.evt_valid = 1'b1;
                            d.evt_code  = EVT_BADLEN;
                            d.evt_len   = hw[CNT_W-1:0];
                            d.prev_mark = 1'b0;
                        end else begin
                            d.len     = hw[CNT_W-1:0];
                            d.flagged = hw[31];
                            if (hw[30:0] == '0)
                                d.phase = PH_TAIL;
                            else if (rev_now && hw[0])
                                d.phase = PH_LEAD_PAD;
                            else
                                d.phase = PH_BODY;
                        end
                    end
                end
            end
            PH_LEAD_PAD: begin
                sto_ready_o = 1'b1;
                if (sto_valid_i) d.phase = PH_BODY;
            end
            PH_BODY: begin
                pay_valid_o = sto_valid_i && !q.flagged;
                pay_last_o  = body_end;
                sto_ready_o = q.flagged || pay_ready_i;
                if (sto_valid_i && sto_ready_o) begin
                    d.cnt = q.cnt + CNT_W'(1);
                    if (body_end) begin
                        d.phase = (!q.rev && q.len[0]) ? PH_TAIL_PAD : PH_TAIL;
                        d.idx   = '0;
                    end
                end
            end
            PH_TAIL_PAD: begin
                sto_ready_o = 1'b1;
                if (sto_valid_i) d.phase = PH_TAIL;
            end
            PH_TAIL: begin
                sto_ready_o = 1'b1;
                if (sto_valid_i) begin
                    d.tail = tw;
                    d.idx  = q.idx + 2'd1;
                    if (q.idx == 2'(WORD_BYTES - 1)) begin
                        d.idx       = '0;
                        d.phase     = PH_HEAD;
                        d.evt_valid = 1'b1;
                        d.evt_len   = q.len;
                        d.prev_mark = 1'b0;
                        if (tw != q.head)    d.evt_code = EVT_BADLEN;
                        else if (q.flagged)  d.evt_code = EVT_FLAGGED;
                        else                 d.evt_code = EVT_GOOD;
                    end
                end
            end
            default: d.phase = PH_HEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_HEAD;
        end else begin
            q <= d;
        end
    end

    assign evt_valid_o = q.evt_valid;
    assign evt_code_o  = q.evt_code;
    assign evt_len_o   = q.evt_len;

    // every record event needs at least four bytes, so events never touch
    assert_evt_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt_valid |=> !q.evt_valid);

    assert_mark_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.evt_valid && (q.evt_code == EVT_MARK || q.evt_code == EVT_END))
        |-> (q.evt_len == '0));

    assert_flagged_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_BODY && q.flagged) |-> !pay_valid_o);

    assert_body_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_BODY) |-> (q.cnt < q.len));

endmodule

// File: rtl/tape_rec_codec.sv
module tape_rec_codec #(
    parameter int MAX_LEN = 65536,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic [30:0]      wr_len,
    input  logic             wr_flag,
    output logic             wr_busy,
    output logic             wr_reject,
    input  logic             pay_in_valid,
    output logic             pay_in_ready,
    input  logic [7:0]       pay_in_data,
    output logic             sto_out_valid,
    input  logic             sto_out_ready,
    output logic [7:0]       sto_out_data,
    input  logic             rd_reverse,
    input  logic             sto_in_valid,
    output logic             sto_in_ready,
    input  logic [7:0]       sto_in_data,
    output logic             pay_out_valid,
    input  logic             pay_out_ready,
    output logic [7:0]       pay_out_data,
    output logic             pay_out_last,
    output logic             evt_valid,
    output logic [2:0]       evt_code,
    output logic [CNT_W-1:0] evt_len
);

    tape_rec_framer #(.MAX_LEN(MAX_LEN)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (wr_start),
        .len_i       (wr_len),
        .flag_i      (wr_flag),
        .busy_o      (wr_busy),
        .reject_o    (wr_reject),
        .pay_valid_i (pay_in_valid),
        .pay_ready_o (pay_in_ready),
        .pay_data_i  (pay_in_data),
        .sto_valid_o (sto_out_valid),
        .sto_ready_i (sto_out_ready),
        .sto_data_o  (sto_out_data)
    );

    tape_rec_deframer #(.MAX_LEN(MAX_LEN)) u_deframer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rev_i       (rd_reverse),
        .sto_valid_i (sto_in_valid),
        .sto_ready_o (sto_in_ready),
        .sto_data_i  (sto_in_data),
        .pay_valid_o (pay_out_valid),
        .pay_ready_i (pay_out_ready),
        .pay_data_o  (pay_out_data),
        .pay_last_o  (pay_out_last),
        .evt_valid_o (evt_valid),
        .evt_code_o  (evt_code),
        .evt_len_o   (evt_len)
    );

endmodule

// File: tb/tb_tape_rec_codec.sv
module tb_tape_rec_codec;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0;
    logic [30:0] wr_len = '0;
    logic        wr_flag = 1'b0;
    logic        wr_busy, wr_reject;
    logic        pay_in_valid = 1'b0;
    logic        pay_in_ready;
    logic [7:0]  pay_in_data = '0;
    logic        sto_out_valid;
    logic        sto_out_ready = 1'b1;
    logic [7:0]  sto_out_data;
    logic        rd_reverse = 1'b0;
    logic        sto_in_valid = 1'b0;
    logic        sto_in_ready;
    logic [7:0]  sto_in_data = '0;
    logic        pay_out_valid;
    logic        pay_out_ready = 1'b1;
    logic [7:0]  pay_out_data;
    logic        pay_out_last;
    logic        evt_valid;
    logic [2:0]  evt_code;
    logic [16:0] evt_len;

    tape_rec_codec dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] strm [0:255];
    int         slen;
    logic [7:0] cap  [0:255];
    int         ncap;
    logic [7:0] pcap [0:255];
    int         npc;
    int         lastpos;
    int         evc [0:15];
    int         evl [0:15];
    int         nev;
    int         pcons;
    bit         rej_seen;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pb(input int len, input int i);
        return 8'((len * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic put_word(input logic [31:0] w);
        for (int b = 0; b < 4; b++) begin
            strm[slen] = w[8*b +: 8];
            slen++;
        end
    endtask

    task automatic build(input int len, input int flag);
        logic [31:0] w;
        w = (len == 0) ? 32'h0 : {flag[0], 31'(len)};
        put_word(w);
        if (len != 0) begin
            for (int i = 0; i < len; i++) begin
                strm[slen] = pb(len, i);
                slen++;
            end
            if (len % 2 == 1) begin
                strm[slen] = 8'h00;
                slen++;
            end
            put_word(w);
        end
    endtask

    task automatic rev_strm();
        for (int i = 0; i < slen / 2; i++) begin
            logic [7:0] t;
            t = strm[i];
            strm[i] = strm[slen - 1 - i];
            strm[slen - 1 - i] = t;
        end
    endtask

    task automatic wr_rec(input int len, input int flag, input int stall);
        int pi;
        int cyc;
        bit first;
        pi = 0; cyc = 0; first = 1'b1; ncap = 0;
        @(negedge clk);
        wr_start = 1'b1; wr_len = 31'(len); wr_flag = flag[0];
        @(negedge clk);
        wr_start = 1'b0;
        while (1) begin
            pay_in_valid  = (pi < len);
            pay_in_data   = pb(len, pi);
            sto_out_ready = (stall != 0) ? !cyc[0] : 1'b1;
            #1;
            if (first) rej_seen = wr_reject;
            first = 1'b0;
            if (!wr_busy) break;
            if (sto_out_valid && sto_out_ready && ncap < 256) begin
                cap[ncap] = sto_out_data;
                ncap++;
            end
            if (pay_in_valid && pay_in_ready) pi++;
            cyc++;
            @(negedge clk);
        end
        pay_in_valid  = 1'b0;
        sto_out_ready = 1'b1;
        pcons = pi;
    endtask

    task automatic feed(input int rev, input int stall);
        int idx;
        int cyc;
        int tail;
        idx = 0; cyc = 0; tail = 0;
        npc = 0; nev = 0; lastpos = -1;
        while (tail < 4) begin
            @(negedge clk);
            sto_in_valid  = (idx < slen);
            sto_in_data   = (idx < slen) ? strm[idx] : 8'h00;
            rd_reverse    = rev[0];
            pay_out_ready = (stall != 0) ? cyc[0] : 1'b1;
            #1;
            if (evt_valid && nev < 16) begin
                evc[nev] = int'(evt_code);
                evl[nev] = int'(evt_len);
                nev++;
            end
            if (pay_out_valid && pay_out_ready && npc < 256) begin
                if (pay_out_last) lastpos = npc;
                pcap[npc] = pay_out_data;
                npc++;
            end
            if (sto_in_valid && sto_in_ready) idx++;
            if (idx >= slen) tail++;
            cyc++;
        end
        sto_in_valid  = 1'b0;
        pay_out_ready = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pm;
        int mism;
        int ecode;
        string req;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12 reset state
        chk(wr_busy == 1'b0,       "R12", int'(wr_busy), 0);
        chk(sto_out_valid == 1'b0, "R12", int'(sto_out_valid), 0);
        chk(pay_out_valid == 1'b0, "R12", int'(pay_out_valid), 0);
        chk(evt_valid == 1'b0,     "R12", int'(evt_valid), 0);
        chk(sto_in_ready == 1'b1,  "R12", int'(sto_in_ready), 1);

        // write sweep: R1, R2, R3, R11
        for (int len = 0; len < 10; len++) begin
            for (int flag = 0; flag < 2; flag++) begin
                for (int stall = 0; stall < 2; stall++) begin
                    slen = 0;
                    build(len, flag);
                    wr_rec(len, flag, stall);
                    req = (len == 0) ? "R3" : ((len % 2 == 1) ? "R2" : "R1");
                    chk(ncap == slen, req, ncap, slen);
                    mism = 0;
                    for (int i = 0; i < slen; i++)
                        if (cap[i] !== strm[i]) mism++;
                    chk(mism == 0, req, mism, 0);
                    chk(pcons == len, (stall != 0) ? "R11" : "R1", pcons, len);
                end
            end
        end

        // R4 oversize write refused
        wr_rec(65537, 0, 0);
        chk(rej_seen == 1'b1, "R4", int'(rej_seen), 1);
        chk(ncap == 0, "R4", ncap, 0);
        @(negedge clk);
        #1;
        chk(wr_reject == 1'b0, "R4", int'(wr_reject), 0);

        // read sweep: R5, R6, R7, R8, R11
        pm = 0;
        for (int len = 0; len < 10; len++) begin
            for (int flag = 0; flag < 2; flag++) begin
                for (int rev = 0; rev < 2; rev++) begin
                    for (int stall = 0; stall < 2; stall++) begin
                        slen = 0;
                        build(len, flag);
                        if (rev != 0) rev_strm();
                        feed(rev, stall);
                        if (len == 0) begin
                            ecode = (pm != 0) ? 4 : 3;
                            pm = 1;
                            req = "R7";
                        end else begin
                            ecode = (flag != 0) ? 2 : 1;
                            pm = 0;
                            req = (flag != 0) ? "R8" : ((rev != 0) ? "R6" : "R5");
                        end
                        chk(nev == 1, req, nev, 1);
                        chk(evc[0] == ecode, req, evc[0], ecode);
                        chk(evl[0] == len, req, evl[0], len);
                        chk(npc == ((flag != 0 || len == 0) ? 0 : len), req, npc,
                            (flag != 0 || len == 0) ? 0 : len);
                        if (flag == 0 && len != 0) begin
                            mism = 0;
                            for (int k = 0; k < len; k++)
                                if (pcap[k] !== pb(len, (rev != 0) ? len - 1 - k : k)) mism++;
                            chk(mism == 0, (stall != 0) ? "R11" : req, mism, 0);
                            chk(lastpos == len - 1, req, lastpos, len - 1);
                        end
                    end
                end
            end
        end

        // R9 trailer mismatch, then a clean record
        slen = 0;
        build(5, 0);
        strm[slen - 4] = strm[slen - 4] ^ 8'h01;
        build(3, 0);
        feed(0, 0);
        chk(nev == 2, "R9", nev, 2);
        chk(evc[0] == 5, "R9", evc[0], 5);
        chk(evc[1] == 1, "R9", evc[1], 1);
        chk(evl[1] == 3, "R9", evl[1], 3);
        chk(npc == 8, "R9", npc, 8);

        // R10 oversized leading word, then a clean record
        slen = 0;
        put_word(32'h0001_0001);
        build(2, 0);
        feed(0, 0);
        chk(nev == 2, "R10", nev, 2);
        chk(evc[0] == 5, "R10", evc[0], 5);
        chk(evc[1] == 1, "R10", evc[1], 1);
        chk(evl[1] == 2, "R10", evl[1], 2);
        chk(npc == 2, "R10", npc, 2);

        // R7 mark, end of tape, then a record breaks the run
        slen = 0;
        build(0, 0);
        build(0, 0);
        build(4, 0);
        build(0, 0);
        feed(0, 0);
        chk(nev == 4, "R7", nev, 4);
        chk(evc[0] == 3, "R7", evc[0], 3);
        chk(evc[1] == 4, "R7", evc[1], 4);
        chk(evc[2] == 1, "R7", evc[2], 1);
        chk(evc[3] == 3, "R7", evc[3], 3);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule